// File: doc/BRIEF.md
# Watchdog and memory control register

This block is one byte-wide special-function register of an 8-bit microcontroller, together with the watchdog counter it controls. Software reaches it with a single-cycle write or a combinational read at one decoded bus address. Three stored bits steer neighbouring logic: one sends data-pointer external accesses to the on-chip EEPROM, one permits an EEPROM byte write, and one chooses which of two data-pointer banks is live. The remaining stored bits enable the watchdog and choose its period through a 3-bit exponential prescaler.

The watchdog counts pulses on a millisecond timebase input. When it reaches the terminal count, it raises a one-cycle reset request. Bit 1 of the register has two roles. Writing it with 1 restarts the watchdog, and it is never stored. Reading it returns the EEPROM ready flag, which is taken from the programmer's busy input. The EEPROM array, its sequencer, the pointer registers and the CPU sit outside this block.

Top module: `wdmc_ctrl`

## Requirements
- R1: After reset, a read at address 0x96 returns 0x02 while `ee_busy` is low. All steering outputs and `wdt_rst` are low.
- R2: A write at address 0x96 stores bits 7:5 (prescaler), 4 (`ee_wr_en`), 3 (`ee_sel`), 2 (`dp_bank`) and 0 (watchdog enable). The stored bits read back at the same positions, and the outputs follow on the cycle after the write edge.
- R3: Writes to any other address leave the register unchanged. Reads at any other address return 0x00.
- R4: Read bit 1 equals the inverse of `ee_busy`: 1 means ready and 0 means programming is in progress.
- R5: Writing 1 to bit 1 is never stored. It only issues a one-cycle restart of the watchdog counter.
- R6: With the watchdog enabled and a tick on every cycle, the first `wdt_rst` comes exactly BASE_TICKS << PS ticks after counting starts. This holds for every prescaler value 0 to 7.
- R7: `wdt_rst` lasts one cycle, the counter reloads to zero, and the next timeout follows after another full period.
- R8: With the enable bit at 0, the counter is held at zero and no `wdt_rst` is produced. Enabling it again starts a full period.
- R9: A restart written part-way through a period zeroes the counter, so the next timeout comes a full period after the restart.
- R10: The counter advances only on cycles with `tick` high. With no ticks, no timeout occurs however long the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| tick | input | 1 | Timebase pulse, one per nominal millisecond |
| ee_busy | input | 1 | EEPROM programmer busy |
| ee_sel | output | 1 | Route pointer accesses to on-chip EEPROM |
| ee_wr_en | output | 1 | EEPROM byte-write permission |
| dp_bank | output | 1 | Data-pointer bank select |
| wdt_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The bench writes all 256 byte values and reads each one back. This separates the stored bit positions from the restart bit and confirms that every steering output follows its own bit. Writes to neighbouring addresses, and reads from them, show that the address decode is exact. The ready flag is read with the busy input at both levels. Timeout intervals are measured for all eight prescaler settings. Each is measured twice in a row, which tells the first period apart from the reload and the pulse width. Separate runs interrupt a period with a restart or a disable, and one run holds the enable bit on while no ticks arrive.

// File: rtl/wdmc_pkg.sv
package wdmc_pkg;

  localparam int WDMC_PS_W = 3;

  // Field layout of the register byte; positions are decoded by neighbours.
  typedef struct packed {
    logic [WDMC_PS_W-1:0] ps;       // bits 7:5
    logic                 ee_wen;   // bit 4
    logic                 ee_sel;   // bit 3
    logic                 dp_bank;  // bit 2
    logic                 wd_en;    // bit 0
  } wdmc_cfg_t;

  function automatic wdmc_cfg_t wdmc_unpack(input logic [7:0] b);
    wdmc_cfg_t c;
    c.ps      = b[7:5];
    c.ee_wen  = b[4];
    c.ee_sel  = b[3];
    c.dp_bank = b[2];
    c.wd_en   = b[0];
    return c;
  endfunction

  function automatic logic [7:0] wdmc_pack(input wdmc_cfg_t c, input logic ready);
    return {c.ps, c.ee_wen, c.ee_sel, c.dp_bank, ready, c.wd_en};
  endfunction

endpackage

// File: rtl/wdmc_regfile.sv
module wdmc_regfile
  import wdmc_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              ee_busy,
  output wdmc_cfg_t         cfg,
  output logic              kick,
  output logic [7:0]        bus_rdata
);

  wdmc_cfg_t cfg_q, cfg_d;
  logic      kick_q, kick_d;
  logic      hit;

  assign hit = (bus_addr == REG_ADDR);

  always_comb begin
    cfg_d  = cfg_q;
    kick_d = 1'b0;
    if (hit && bus_wr) begin
      cfg_d  = wdmc_unpack(bus_wdata);
      kick_d = bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      kick_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      kick_q <= kick_d;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (hit) bus_rdata = wdmc_pack(cfg_q, ~ee_busy);
  end

  assign cfg  = cfg_q;
  assign kick = kick_q;

endmodule

// File: rtl/wdmc_limit.sv
module wdmc_limit #(
  parameter int BASE_TICKS = 16,
  parameter int PS_W       = 3,
  parameter int CNT_W      = 12
) (
  input  logic [PS_W-1:0]  ps,
  output logic [CNT_W-1:0] term
);

  localparam int STEPS = 1 << PS_W;

  logic [CNT_W-1:0] lut [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign lut[g] = CNT_W'(BASE_TICKS) << g;
  end

  assign term = lut[ps];

endmodule

// File: rtl/wdmc_counter.sv
module wdmc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             fire
);

  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             fire_q, fire_d;

  assign last = term - {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (!en || kick) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= last) begin
        cnt_d  = '0;
        fire_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign cnt  = cnt_q;
  assign fire = fire_q;

endmodule

// File: rtl/wdmc_ctrl.sv
module wdmc_ctrl
  import wdmc_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'h96,
  parameter int                BASE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick,
  input  logic              ee_busy,
  output logic              ee_sel,
  output logic              ee_wr_en,
  output logic              dp_bank,
  output logic              wdt_rst
);

  localparam int MAX_TERM = BASE_TICKS << ((1 << WDMC_PS_W) - 1);
  localparam int CNT_W    = $clog2(MAX_TERM) + 1;

  // Reset asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  wdmc_cfg_t        cfg;
  logic             kick;
  logic [CNT_W-1:0] term, cnt;

  wdmc_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .ee_busy(ee_busy), .cfg(cfg), .kick(kick),
    .bus_rdata(bus_rdata)
  );

  wdmc_limit #(.BASE_TICKS(BASE_TICKS), .PS_W(WDMC_PS_W), .CNT_W(CNT_W)) u_limit (
    .ps(cfg.ps), .term(term)
  );

  wdmc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(cfg.wd_en), .kick(kick), .tick(tick),
    .term(term), .cnt(cnt), .fire(wdt_rst)
  );

  assign ee_sel   = cfg.ee_sel;
  assign ee_wr_en = cfg.ee_wen;
  assign dp_bank  = cfg.dp_bank;

endmodule

// File: rtl/wdmc_ctrl_chk.sv
module wdmc_ctrl_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h96,
  parameter int                CNT_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              wr_kick_bit,
  input logic [7:0]        bus_rdata,
  input logic              ee_busy,
  input logic              en,
  input logic              kick,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term,
  input logic              wdt_rst
);

  assert_other_addr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> (bus_rdata == 8'h00));

  assert_ready_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_ADDR) |-> (bus_rdata[1] == !ee_busy));

  assert_kick_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> $past(bus_wr && (bus_addr == REG_ADDR) && wr_kick_bit));

  assert_fire_at_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kick && tick && ({1'b0, cnt} + 1'b1 >= {1'b0, term})) |=> wdt_rst);

  assert_pulse_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  assert_disabled_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !wdt_rst));

  assert_kick_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));

  assert_fire_needs_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(tick));

endmodule

bind wdmc_ctrl wdmc_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wr_kick_bit(bus_wdata[1]), .bus_rdata(bus_rdata), .ee_busy(ee_busy),
  .en(cfg.wd_en), .kick(kick), .tick(tick), .cnt(cnt), .term(term),
  .wdt_rst(wdt_rst)
);

// File: tb/wdmc_ctrl_tb.sv
`timescale 1ns/1ps
module wdmc_ctrl_tb;

  localparam logic [7:0] RA   = 8'h96;
  localparam int         BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tick = 1'b0;
  logic       ee_busy = 1'b0;
  logic       ee_sel, ee_wr_en, dp_bank, wdt_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wdmc_ctrl #(.REG_ADDR(RA), .BASE_TICKS(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .ee_busy(ee_busy), .ee_sel(ee_sel), .ee_wr_en(ee_wr_en),
    .dp_bank(dp_bank), .wdt_rst(wdt_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Called at a negedge; holds tick high and counts edges until wdt_rst.
  task automatic wait_fire(input int limit, output int k);
    k = 0;
    tick = 1'b1;
    do begin
      @(negedge clk);
      k++;
    end while (!wdt_rst && k < limit);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: bench hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int k, k2, seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(RA, d);
    chk("R1 reset read", d, 8'h02);
    chk("R1 outputs", {ee_sel, ee_wr_en, dp_bank, wdt_rst}, 0);

    // R2 / R5: exhaustive byte sweep, bit 1 never stored
    seen = 0;
    for (int v = 0; v < 256; v++) begin
      wr(RA, 8'(v));
      rd(RA, d);
      chk("R2 R5 readback", d, (v & 8'hFD) | 8'h02);
      chk("R2 outputs", {ee_wr_en, ee_sel, dp_bank}, (v >> 2) & 7);
      if (wdt_rst) seen++;
    end
    chk("R10 no fire without ticks during sweep", seen, 0);

    // R3: neighbouring addresses
    wr(RA, 8'h00);
    wr(8'h95, 8'hFF);
    wr(8'h97, 8'hFF);
    wr(8'h16, 8'hFF);
    rd(RA, d);
    chk("R3 other-address writes ignored", d, 8'h02);
    chk("R3 outputs unchanged", {ee_sel, ee_wr_en, dp_bank}, 0);
    rd(8'h97, d);
    chk("R3 other-address read", d, 0);
    rd(8'h00, d);
    chk("R3 other-address read 0", d, 0);

    // R4: ready flag
    ee_busy = 1'b1;
    rd(RA, d);
    chk("R4 busy reads 0", d[1], 0);
    ee_busy = 1'b0;
    rd(RA, d);
    chk("R4 ready reads 1", d[1], 1);

    // R6 / R7: period for each prescaler, twice in a row
    for (int ps = 0; ps < 8; ps++) begin
      wr(RA, 8'(ps << 5));
      wr(RA, 8'((ps << 5) | 1));
      wait_fire(5000, k);
      chk($sformatf("R6 period ps=%0d", ps), k, BASE << ps);
      wait_fire(5000, k2);
      chk($sformatf("R7 reload period ps=%0d", ps), k2, BASE << ps);
      wr(RA, 8'h00);
    end

    // R8: disable mid-period, hold, re-enable
    wr(RA, 8'h01);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    wr(RA, 8'h00);
    seen = 0;
    tick = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    tick = 1'b0;
    chk("R8 no reset while disabled", seen, 0);
    wr(RA, 8'h01);
    wait_fire(5000, k);
    chk("R8 full period after re-enable", k, BASE);
    wr(RA, 8'h00);

    // R9: restart mid-period
    wr(RA, 8'h01);
    tick = 1'b1;
    repeat (10) @(negedge clk);
    tick = 1'b0;
    wr(RA, 8'h03);
    @(negedge clk);
    rd(RA, d);
    chk("R9 R5 restart not stored", d, 8'h03);
    wait_fire(5000, k);
    chk("R9 full period after restart", k, BASE);
    wr(RA, 8'h00);

    // R10: enabled but no ticks
    wr(RA, 8'h01);
    seen = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wdt_rst) seen++;
    end
    chk("R10 no fire without ticks", seen, 0);
    wait_fire(5000, k);
    chk("R10 counter did not advance", k, BASE);
    wr(RA, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule